// File: doc/BRIEF.md
# Flash Bank Range Selector

This block works out which flash banks a planned copy will touch. It takes a destination offset inside the flash, a source physical offset and a byte count. It returns one select bit per bank in each of three address spaces. The low space has six banks of mixed size. The mid space has two 128 KiB banks. The high space has up to twenty 128 KiB banks.

The block also checks the flash configuration codes and derives the total flash size from the size code. It checks that the transfer is aligned and fits inside the flash. It rejects a copy whose source and destination share any bank. A controller pulses a request with the operands held steady. One cycle later it reads a registered result code, the destination bank masks and the flash size.

The comparison against each bank uses the first address and the end address, where the end address is start plus count. That end address is itself included, so a transfer ending exactly on a bank boundary also marks the next bank. This is a deliberately conservative rule.

Top module: `flash_bank_selector`

## Requirements
- R1: While reset is asserted and after its release, until the first request: `rsp_valid` is 0, `rsp_err` is 0, all three masks are 0 and `flash_bytes` is 0.
- R2: A result appears in the cycle after a cycle with `req` high, with `rsp_valid` high for exactly that one cycle. All other outputs hold their values until the next request.
- R3: The configuration is valid only when `low_code` is 6 and `mid_code` is 0. Otherwise `rsp_err` is 1 and `flash_bytes` is 0.
- R4: `size_code` 5, 7 and 11 select 8, 12 and 20 high banks, and `flash_bytes` = 512 KiB + 128 KiB × banks. Any other code gives `rsp_err` 2 and `flash_bytes` 0.
- R5: `rsp_err` is 3 in any of these cases: `dst_off` has a nonzero value in bits [2:0]; `byte_cnt` has a nonzero value in bits [2:0]; `dst_off + byte_cnt` exceeds `flash_bytes`.
- R6: Each mask bit stands for one bank; the bank's bit is set unless its last byte is below `dst_off` or its first byte is above `dst_off + byte_cnt`. The bank layout is as follows:
  - `low_sel` bit i covers banks, in ascending order from offset 0, of 16, 16, 48, 48, 64 and 64 KiB.
  - `mid_sel` bit j covers 256 KiB + j × 128 KiB.
  - `high_sel` bit k covers 512 KiB + k × 128 KiB, for all 20 bits.
- R7: The source masks are formed the same way from `src_off`. If any bank is set in both the source and the destination masks of the same space, `rsp_err` is 4.
- R8: When several errors apply, the reported code is the first one in this order: configuration (1), size (2), range (3), overlap (4). Code 0 means success.
- R9: Whenever `rsp_err` is nonzero, `low_sel`, `mid_sel` and `high_sel` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request strobe; operands sampled on this cycle |
| dst_off | input | AW | Destination offset inside the flash |
| src_off | input | AW | Source physical offset |
| byte_cnt | input | AW | Transfer length in bytes |
| low_code | input | 4 | Low-space layout code |
| mid_code | input | 4 | Mid-space layout code |
| size_code | input | 4 | High-space size code |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_err | output | 3 | 0 ok, 1 config, 2 size, 3 range, 4 overlap |
| low_sel | output | 6 | Destination low-space bank mask |
| mid_sel | output | 2 | Destination mid-space bank mask |
| high_sel | output | 20 | Destination high-space bank mask |
| flash_bytes | output | AW | Total flash size in bytes |

## Verification
The bench aims at the inclusive end compare with transfers that end exactly on a bank boundary. An exclusive compare would drop the next bank's bit. It also uses transfers that end exactly at the flash size and eight bytes beyond it. An off-by-one limit test would flip between code 0 and code 3 on these. A combined bad configuration and bad size catches a reversed priority, and a combined overlap and range error does the same. The uneven low banks are crossed by a multi-bank span, where a uniform bank-size assumption would mark the wrong bits. Randomized legal and illegal requests over all three size codes are compared against an independent model of the bank map.

// File: rtl/flash_bank_selector.sv
module flash_bank_selector #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [AW-1:0] dst_off,
  input  logic [AW-1:0] src_off,
  input  logic [AW-1:0] byte_cnt,
  input  logic [3:0]    low_code,
  input  logic [3:0]    mid_code,
  input  logic [3:0]    size_code,
  output logic          rsp_valid,
  output logic [2:0]    rsp_err,
  output logic [5:0]    low_sel,
  output logic [1:0]    mid_sel,
  output logic [19:0]   high_sel,
  output logic [AW-1:0] flash_bytes
);
  localparam int NL = 6;
  localparam int NM = 2;
  localparam int NH = 20;
  localparam logic [2:0] E_OK = 3'd0, E_CFG = 3'd1, E_SIZE = 3'd2,
                         E_RANGE = 3'd3, E_OVL = 3'd4;

  function automatic logic [AW:0] kib(int k);
    return (AW+1)'(k) << 10;
  endfunction

  function automatic int low_edge(int i);
    case (i)
      0: return 0;
      1: return 16;
      2: return 32;
      3: return 80;
      4: return 128;
      5: return 192;
      default: return 256;
    endcase
  endfunction

  function automatic logic touch(logic [AW:0] lo, logic [AW:0] hi,
                                 logic [AW:0] first, logic [AW:0] last);
    return !(hi < first || lo > last);
  endfunction

  logic [AW:0] d_first, d_last, s_first, s_last;
  assign d_first = {1'b0, dst_off};
  assign d_last  = d_first + {1'b0, byte_cnt};
  assign s_first = {1'b0, src_off};
  assign s_last  = s_first + {1'b0, byte_cnt};

  logic [NL-1:0] d_low,  s_low;
  logic [NM-1:0] d_mid,  s_mid;
  logic [NH-1:0] d_high, s_high;

  for (genvar i = 0; i < NL; i++) begin : g_low
    localparam logic [AW:0] LO = kib(low_edge(i));
    localparam logic [AW:0] HI = kib(low_edge(i + 1)) - 1'b1;
    assign d_low[i] = touch(LO, HI, d_first, d_last);
    assign s_low[i] = touch(LO, HI, s_first, s_last);
  end

  for (genvar j = 0; j < NM; j++) begin : g_mid
    localparam logic [AW:0] LO = kib(256 + 128 * j);
    localparam logic [AW:0] HI = kib(384 + 128 * j) - 1'b1;
    assign d_mid[j] = touch(LO, HI, d_first, d_last);
    assign s_mid[j] = touch(LO, HI, s_first, s_last);
  end

  for (genvar k = 0; k < NH; k++) begin : g_high
    localparam logic [AW:0] LO = kib(512 + 128 * k);
    localparam logic [AW:0] HI = kib(640 + 128 * k) - 1'b1;
    assign d_high[k] = touch(LO, HI, d_first, d_last);
    assign s_high[k] = touch(LO, HI, s_first, s_last);
  end

  logic [4:0] hcount;
  logic       size_bad;
  always_comb begin
    size_bad = 1'b0;
    case (size_code)
      4'd5:    hcount = 5'd8;
      4'd7:    hcount = 5'd12;
      4'd11:   hcount = 5'd20;
      default: begin hcount = 5'd0; size_bad = 1'b1; end
    endcase
  end

  logic [AW-1:0] total;
  assign total = kib(512)[AW-1:0] + ({{(AW-5){1'b0}}, hcount} << 17);

  logic cfg_bad, rng_bad, ovl;
  assign cfg_bad = (low_code != 4'd6) || (mid_code != 4'd0);
  assign rng_bad = (dst_off[2:0] != 3'd0) || (byte_cnt[2:0] != 3'd0) ||
                   (d_last > {1'b0, total});
  assign ovl     = |(d_low & s_low) || |(d_mid & s_mid) || |(d_high & s_high);

  logic [2:0] err_n;
  assign err_n = cfg_bad  ? E_CFG  :
                 size_bad ? E_SIZE :
                 rng_bad  ? E_RANGE :
                 ovl      ? E_OVL  : E_OK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_err     <= E_OK;
      low_sel     <= '0;
      mid_sel     <= '0;
      high_sel    <= '0;
      flash_bytes <= '0;
    end else begin
      rsp_valid <= req;
      if (req) begin
        rsp_err     <= err_n;
        low_sel     <= (err_n == E_OK) ? d_low  : '0;
        mid_sel     <= (err_n == E_OK) ? d_mid  : '0;
        high_sel    <= (err_n == E_OK) ? d_high : '0;
        flash_bytes <= (cfg_bad || size_bad) ? '0 : total;
      end
    end
  end
endmodule

// File: rtl/flash_bank_selector_chk.sv
module flash_bank_selector_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic [3:0]    low_code,
  input logic [3:0]    mid_code,
  input logic [3:0]    size_code,
  input logic          rsp_valid,
  input logic [2:0]    rsp_err,
  input logic [5:0]    low_sel,
  input logic [1:0]    mid_sel,
  input logic [19:0]   high_sel,
  input logic [AW-1:0] flash_bytes
);
  // R2
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> rsp_valid);
  // R2
  valid_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !rsp_valid);
  // R2
  outputs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> $stable(rsp_err) && $stable(low_sel) && $stable(mid_sel) &&
             $stable(high_sel) && $stable(flash_bytes));
  // R3
  cfg_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req && (low_code != 4'd6 || mid_code != 4'd0) |=> rsp_err == 3'd1 && flash_bytes == '0);
  // R4
  size_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req && low_code == 4'd6 && mid_code == 4'd0 &&
    size_code != 4'd5 && size_code != 4'd7 && size_code != 4'd11
    |=> rsp_err == 3'd2);
  // R9
  err_clears_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err != 3'd0 |-> low_sel == '0 && mid_sel == '0 && high_sel == '0);
  // R6
  ok_has_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err == 3'd0 |-> (|low_sel || |mid_sel || |high_sel));
  // R8
  err_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err <= 3'd4);
endmodule

bind flash_bank_selector flash_bank_selector_chk #(.AW(AW)) chk_i (.*);

// File: tb/flash_bank_selector_tb_top.sv
`timescale 1ns/1ps
module flash_bank_selector_tb_top;
  localparam int AW = 32;

  typedef struct {
    logic [2:0]  err;
    logic [5:0]  lo;
    logic [1:0]  mi;
    logic [19:0] hi;
    longint      tot;
    string       tag;
  } exp_t;

  logic clk = 0, rst_n = 0, req = 0;
  logic [AW-1:0] dst_off = '0, src_off = '0, byte_cnt = '0;
  logic [3:0] low_code = 4'd6, mid_code = 4'd0, size_code = 4'd7;
  logic rsp_valid;
  logic [2:0] rsp_err;
  logic [5:0] low_sel;
  logic [1:0] mid_sel;
  logic [19:0] high_sel;
  logic [AW-1:0] flash_bytes;

  int checks = 0, fails = 0, issued = 0, seen = 0;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  flash_bank_selector #(.AW(AW)) dut_i (.*);

  function automatic bit hits(longint lo, longint hi, longint f, longint l);
    return !(hi < f || lo > l);
  endfunction

  function automatic void masks(longint f, longint n, output logic [5:0] lo,
                                output logic [1:0] mi, output logic [19:0] hi);
    longint edges[7] = '{0, 16, 32, 80, 128, 192, 256};
    longint l = f + n;
    for (int i = 0; i < 6; i++) lo[i] = hits(edges[i]*1024, edges[i+1]*1024 - 1, f, l);
    for (int j = 0; j < 2; j++) mi[j] = hits((256 + 128*j)*1024, (384 + 128*j)*1024 - 1, f, l);
    for (int k = 0; k < 20; k++) hi[k] = hits((512 + 128*k)*1024, (640 + 128*k)*1024 - 1, f, l);
  endfunction

  function automatic exp_t model(longint d, longint s, longint n, int lc, int mc, int sc);
    exp_t e;
    int hb;
    logic [5:0] dl, sl; logic [1:0] dm, sm; logic [19:0] dh, sh;
    hb = (sc == 5) ? 8 : (sc == 7) ? 12 : (sc == 11) ? 20 : 0;
    e.tot = 512*1024 + longint'(hb) * 128*1024;
    masks(d, n, dl, dm, dh);
    masks(s, n, sl, sm, sh);
    if (lc != 6 || mc != 0) e.err = 3'd1;
    else if (hb == 0) e.err = 3'd2;
    else if ((d % 8) != 0 || (n % 8) != 0 || d + n > e.tot) e.err = 3'd3;
    else if ((dl & sl) != 0 || (dm & sm) != 0 || (dh & sh) != 0) e.err = 3'd4;
    else e.err = 3'd0;
    if (e.err == 3'd1 || e.err == 3'd2) e.tot = 0;
    e.lo = (e.err == 0) ? dl : '0;
    e.mi = (e.err == 0) ? dm : '0;
    e.hi = (e.err == 0) ? dh : '0;
    return e;
  endfunction

  task automatic check(bit ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic run(longint d, longint s, longint n, int lc, int mc, int sc, string tag);
    exp_t e;
    @(negedge clk);
    dst_off = AW'(d); src_off = AW'(s); byte_cnt = AW'(n);
    low_code = 4'(lc); mid_code = 4'(mc); size_code = 4'(sc);
    req = 1;
    e = model(d, s, n, lc, mc, sc);
    e.tag = tag;
    sb.push_back(e);
    issued++;
    @(negedge clk);
    req = 0;
    dst_off = '1; src_off = '1; byte_cnt = '1;
    @(negedge clk);
    check(rsp_valid == 0, {tag, " R2 pulse width"}, rsp_valid, 0);
    check(rsp_err == e.err, {tag, " R2 hold"}, rsp_err, e.err);
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      exp_t e;
      seen++;
      if (sb.size() == 0) check(0, "R2 unexpected response", 1, 0);
      else begin
        e = sb.pop_front();
        check(rsp_err == e.err, {e.tag, " err"}, rsp_err, e.err);
        check(low_sel == e.lo, {e.tag, " R6 low_sel"}, low_sel, e.lo);
        check(mid_sel == e.mi, {e.tag, " R6 mid_sel"}, mid_sel, e.mi);
        check(high_sel == e.hi, {e.tag, " R6 high_sel"}, high_sel, e.hi);
        check(flash_bytes == AW'(e.tot), {e.tag, " R4 flash_bytes"}, flash_bytes, e.tot);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rsp_valid == 0 && rsp_err == 0 && low_sel == 0 && mid_sel == 0 &&
          high_sel == 0 && flash_bytes == 0, "R1 reset state", rsp_err, 0);
    rst_n = 1;
    @(negedge clk);
    check(rsp_valid == 0 && flash_bytes == 0, "R1 after release", rsp_valid, 0);

    run(0, 'h100000, 16, 6, 0, 7, "R6 low bank0");
    run('h4000 - 8, 'h80000, 8, 6, 0, 7, "R6 boundary end marks next bank");
    run('h8000, 'h100000, 'h30000, 6, 0, 7, "R6 span uneven low banks");
    run('h40000, 'h200000, 'h20000, 6, 0, 7, "R6 mid banks");
    run(0, 0, 8, 5, 0, 7, "R3 low code bad");
    run(0, 0, 8, 6, 1, 7, "R3 mid code bad");
    run(0, 'h100000, 8, 6, 0, 6, "R4 size code bad");
    run(0, 'h100000, 8, 6, 0, 5, "R4 size 5");
    run('h2E0000, 0, 64, 6, 0, 11, "R4 size 11 top bank");
    run(0, 0, 8, 6, 2, 9, "R8 cfg over size");
    run(4, 'h100000, 8, 6, 0, 7, "R5 misaligned start");
    run(0, 'h100000, 12, 6, 0, 7, "R5 odd count");
    run('h180000 - 'h20, 0, 'h20, 6, 0, 5, "R5 end at size");
    run('h180000 - 'h18, 0, 'h20, 6, 0, 5, "R5 past size");
    run('h40000, 'h40100, 8, 6, 0, 7, "R7 overlap mid");
    run('h1FFFF8, 'h1FFF00, 16, 6, 0, 7, "R8 range over overlap");
    run(0, 8, 8, 6, 0, 7, "R9 overlap clears masks");
    for (int i = 0; i < 60; i++) begin
      int sc = (i % 3 == 0) ? 5 : (i % 3 == 1) ? 7 : 11;
      longint d = longint'($urandom_range(0, 'h300000)) & ~longint'((i % 5 == 0) ? 0 : 7);
      longint s = longint'($urandom_range(0, 'h300000)) & ~longint'(7);
      longint n = longint'($urandom_range(0, 'h40000)) & ~longint'((i % 7 == 0) ? 0 : 7);
      run(d, s, n, 6, (i % 11 == 0) ? 1 : 0, sc, "R7 random mix");
    end
    repeat (3) @(negedge clk);
    check(seen == issued && sb.size() == 0, "R2 all responses seen", seen, issued);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule